// File: doc/BRIEF.md
# Sector Write-Protection Status Unit

This unit keeps the protection status byte of a serial flash device and decides, for each program or erase request, whether the request may go ahead. The array is split into a parameterised number of equal sectors, eight by default. A two-bit level field protects nothing, the top eighth, the top quarter or the top half of the array, counted down from the highest sector. A separate whole-array bit protects every sector. A hardware-lock enable bit in the same byte decides whether an active-low lock pin can freeze the status byte.

The command decoder drives one-cycle pulses into the unit: set or clear the write-enable latch, write the status byte, or request an operation. An operation request carries a kind, either a single-sector program/erase or a chip erase, and a target sector. The unit answers every operation request with exactly one pulse, either grant or deny, one cycle later. The write-enable latch is used up by every status write or operation request that is evaluated. While the device reports busy, requests change nothing and operation requests are denied.

Top module: `wp_status_unit`

## Requirements
- R1: After synchronous reset the status byte reads 8'h00 and neither grant nor deny is asserted.
- R2: A set-latch pulse while not busy sets status bit 1 (write-enable latch) at the next edge. A clear-latch pulse clears it at any time. A clear, or an evaluated status write or operation request in the same cycle, wins over a set.
- R3: A status write that is accepted loads bit 7 (hardware-lock enable), bit 4 (whole array), and bits 3:2 (protection level) from the data in one cycle, all together. Data bits 6:5 and 1:0 are ignored, and status bits 6:5 read 0.
- R4: A status write made while the write-enable latch is 0 leaves bits 7, 4, 3 and 2 unchanged.
- R5: While bit 7 is 0, the lock pin has no effect: a status write with the latch set is accepted even with the pin low.
- R6: While bit 7 is 1 and the lock pin is low, a status write is refused and bits 7, 4, 3 and 2 are unchanged.
- R7: Every status write or operation request made while not busy clears the write-enable latch at the next edge, whether it is accepted, granted, refused or denied.
- R8: The protected set is sector N-1 for level 01, sectors N-2 to N-1 for level 10, and sectors N/2 to N-1 for level 11. Level 00 protects nothing. Bit 4 protects all sectors whatever the level. With the default N=8, level 11 covers sectors 4 to 7.
- R9: A sector request (kind 0) is granted one cycle later if the latch is set, the device is not busy and the target sector is unprotected. Otherwise it is denied. Each request gives exactly one grant or deny pulse.
- R10: A chip-erase request (kind 1) is granted only when the latch is set, the device is not busy and no sector is protected.
- R11: While busy, a set-latch pulse and a status write change nothing, and an operation request is denied without using up the latch.
- R12: Status bit 0 shows the busy input as registered at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wel_set_i | input | 1 | Set the write-enable latch |
| wel_clr_i | input | 1 | Clear the write-enable latch |
| hw_lock_n_i | input | 1 | Active-low hardware lock pin |
| busy_i | input | 1 | A self-timed cycle is in progress |
| sr_wr_i | input | 1 | Status write request |
| sr_data_i | input | 8 | Status write data |
| op_req_i | input | 1 | Program or erase request |
| op_chip_i | input | 1 | Request kind: 0 sector, 1 chip erase |
| op_sector_i | input | SECT_W | Target sector of the request |
| status_o | output | 8 | Status byte for readback |
| op_grant_o | output | 1 | Request allowed (one-cycle pulse) |
| op_deny_o | output | 1 | Request refused (one-cycle pulse) |

## Verification
Assertions check several things on every cycle. Grant and deny never rise together, and each request gets an answer. A locked or unlatched status write leaves the byte unchanged. The latch is used up by every evaluated request and cannot be set while busy. Whole-array or nonzero-level protection denies a chip erase. The bench scenarios are needed to show the exact protected range for each level at the boundary sectors, the byte that an accepted write loads including the ignored data bits, and the pin's effect turning on and off as the enable bit changes. A random phase compares every output against a behavioural model on each clock.

// File: rtl/wpsu_pkg.sv
package wpsu_pkg;
  localparam int SR_W       = 8;
  localparam int BIT_BUSY   = 0;
  localparam int BIT_WEL    = 1;
  localparam int BIT_LVL_LO = 2;
  localparam int BIT_LVL_HI = 3;
  localparam int BIT_ALL    = 4;
  localparam int BIT_LOCKEN = 7;

  typedef enum logic [1:0] {
    LVL_NONE    = 2'b00,
    LVL_EIGHTH  = 2'b01,
    LVL_QUARTER = 2'b10,
    LVL_HALF    = 2'b11
  } prot_level_e;

  typedef struct packed {
    logic        lock_en;
    logic        all_prot;
    prot_level_e level;
  } prot_cfg_t;

  // Number of top sectors covered by a configuration
  function automatic int covered_count(prot_cfg_t c, int n);
    if (c.all_prot) return n;
    case (c.level)
      LVL_EIGHTH:  return n / 8;
      LVL_QUARTER: return n / 4;
      LVL_HALF:    return n / 2;
      default:     return 0;
    endcase
  endfunction
endpackage

// File: rtl/wpsu_wel.sv
module wpsu_wel (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic consume_i,
  input  logic busy_i,
  output logic wel_o
);
  always_ff @(posedge clk) begin
    if (rst)                    wel_o <= 1'b0;
    else if (clr_i || consume_i) wel_o <= 1'b0;
    else if (set_i && !busy_i)  wel_o <= 1'b1;
  end

  // R7: an evaluated request always uses up the latch
  a_r7_wel_consumed: assert property (@(posedge clk) disable iff (rst)
    consume_i |=> !wel_o);
  // R11: latch cannot be set while busy
  a_r11_no_set_busy: assert property (@(posedge clk) disable iff (rst)
    (busy_i && !wel_o) |=> !wel_o);
  // R2: clear pulse wins
  a_r2_clear_wins: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !wel_o);
endmodule

// File: rtl/wpsu_sreg.sv
module wpsu_sreg
  import wpsu_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wr_i,
  input  prot_cfg_t wdata_i,
  input  logic      wel_i,
  input  logic      busy_i,
  input  logic      hw_lock_n_i,
  output prot_cfg_t cfg_o
);
  logic pin_locked;
  logic accept;

  assign pin_locked = cfg_o.lock_en && !hw_lock_n_i;
  assign accept     = wr_i && !busy_i && wel_i && !pin_locked;

  // Single-cycle replace of all protection fields together
  always_ff @(posedge clk) begin
    if (rst)         cfg_o <= '{lock_en: 1'b0, all_prot: 1'b0, level: LVL_NONE};
    else if (accept) cfg_o <= wdata_i;
  end

  // R4: no latch, no change
  a_r4_needs_wel: assert property (@(posedge clk) disable iff (rst)
    (wr_i && !wel_i) |=> $stable(cfg_o));
  // R6: locked pin freezes the byte
  a_r6_pin_lock: assert property (@(posedge clk) disable iff (rst)
    (wr_i && cfg_o.lock_en && !hw_lock_n_i) |=> $stable(cfg_o));
  // R5: pin ignored while lock enable is clear
  a_r5_pin_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_i && wel_i && !busy_i && !cfg_o.lock_en) |=> (cfg_o == $past(wdata_i)));
  // R11: busy blocks writes
  a_r11_busy_sr: assert property (@(posedge clk) disable iff (rst)
    (wr_i && busy_i) |=> $stable(cfg_o));
endmodule

// File: rtl/wpsu_range.sv
module wpsu_range
  import wpsu_pkg::*;
#(
  parameter int NUM_SECTORS = 8,
  parameter int SECT_W      = $clog2(NUM_SECTORS)
) (
  input  prot_cfg_t         cfg_i,
  input  logic [SECT_W-1:0] sector_i,
  output logic              sector_prot_o,
  output logic              any_prot_o
);
  int                     covered;
  logic [NUM_SECTORS-1:0] mask;

  always_comb covered = covered_count(cfg_i, NUM_SECTORS);

  // One comparator per sector: protected when in the top 'covered' sectors
  for (genvar s = 0; s < NUM_SECTORS; s++) begin : g_sect
    assign mask[s] = (s >= NUM_SECTORS - covered);
  end

  assign sector_prot_o = mask[sector_i];
  assign any_prot_o    = |mask;
endmodule

// File: rtl/wp_status_unit.sv
module wp_status_unit
  import wpsu_pkg::*;
#(
  parameter int NUM_SECTORS = 8,
  localparam int SECT_W     = $clog2(NUM_SECTORS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wel_set_i,
  input  logic              wel_clr_i,
  input  logic              hw_lock_n_i,
  input  logic              busy_i,
  input  logic              sr_wr_i,
  input  logic [SR_W-1:0]   sr_data_i,
  input  logic              op_req_i,
  input  logic              op_chip_i,
  input  logic [SECT_W-1:0] op_sector_i,
  output logic [SR_W-1:0]   status_o,
  output logic              op_grant_o,
  output logic              op_deny_o
);
  prot_cfg_t cfg;
  prot_cfg_t wdata;
  logic      wel;
  logic      busy_q;
  logic      consume;
  logic      sector_prot;
  logic      any_prot;
  logic      target_ok;
  logic      allow;
  logic      unused_data;

  assign wdata.lock_en  = sr_data_i[BIT_LOCKEN];
  assign wdata.all_prot = sr_data_i[BIT_ALL];
  assign wdata.level    = prot_level_e'(sr_data_i[BIT_LVL_HI:BIT_LVL_LO]);
  assign unused_data    = ^{sr_data_i[6:5], sr_data_i[1:0]};

  assign consume = (sr_wr_i || op_req_i) && !busy_i;

  wpsu_wel u_wel (
    .clk       (clk),
    .rst       (rst),
    .set_i     (wel_set_i),
    .clr_i     (wel_clr_i),
    .consume_i (consume),
    .busy_i    (busy_i),
    .wel_o     (wel)
  );

  wpsu_sreg u_sreg (
    .clk         (clk),
    .rst         (rst),
    .wr_i        (sr_wr_i),
    .wdata_i     (wdata),
    .wel_i       (wel),
    .busy_i      (busy_i),
    .hw_lock_n_i (hw_lock_n_i),
    .cfg_o       (cfg)
  );

  wpsu_range #(.NUM_SECTORS(NUM_SECTORS), .SECT_W(SECT_W)) u_range (
    .cfg_i         (cfg),
    .sector_i      (op_sector_i),
    .sector_prot_o (sector_prot),
    .any_prot_o    (any_prot)
  );

  assign target_ok = op_chip_i ? !any_prot : !sector_prot;
  assign allow     = !busy_i && wel && target_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_grant_o <= 1'b0;
      op_deny_o  <= 1'b0;
      busy_q     <= 1'b0;
    end else begin
      op_grant_o <= op_req_i && allow;
      op_deny_o  <= op_req_i && !allow;
      busy_q     <= busy_i;
    end
  end

  always_comb begin
    status_o             = '0;
    status_o[BIT_BUSY]   = busy_q;
    status_o[BIT_WEL]    = wel;
    status_o[BIT_LVL_HI:BIT_LVL_LO] = cfg.level;
    status_o[BIT_ALL]    = cfg.all_prot;
    status_o[BIT_LOCKEN] = cfg.lock_en;
  end

  // R9: at most one answer, and every request answered
  a_r9_one_answer: assert property (@(posedge clk) disable iff (rst)
    $onehot0({op_grant_o, op_deny_o}));
  a_r9_answered: assert property (@(posedge clk) disable iff (rst)
    op_req_i |=> (op_grant_o || op_deny_o));
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !op_req_i |=> !(op_grant_o || op_deny_o));
  // R11: busy request denied
  a_r11_busy_deny: assert property (@(posedge clk) disable iff (rst)
    (op_req_i && busy_i) |=> op_deny_o);
  // R10: chip erase refused under any protection
  a_r10_chip_prot: assert property (@(posedge clk) disable iff (rst)
    (op_req_i && op_chip_i && (status_o[BIT_ALL] || status_o[BIT_LVL_HI:BIT_LVL_LO] != 2'b00))
    |=> !op_grant_o);
  // R8: whole-array bit covers everything, level 00 covers nothing
  a_r8_all_bit: assert property (@(posedge clk) disable iff (rst)
    cfg.all_prot |-> (any_prot && sector_prot));
  a_r8_none: assert property (@(posedge clk) disable iff (rst)
    (!cfg.all_prot && cfg.level == LVL_NONE) |-> !any_prot);
  // R12: busy bit follows input by one edge
  a_r12_busy_bit: assert property (@(posedge clk) disable iff (rst)
    busy_i |=> status_o[BIT_BUSY]);
endmodule

// File: tb/sim_wp_status_unit.sv
module sim_wp_status_unit;
  logic       clk = 1'b0;
  logic       rst;
  logic       wel_set, wel_clr, pin_n, busy, sr_wr, op_req, op_chip;
  logic [7:0] sr_data;
  logic [2:0] op_sector;
  logic [7:0] status;
  logic       grant, deny;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  // Behavioural reference state
  bit m_wel, m_lock, m_all, m_busy, m_grant, m_deny;
  int m_lvl;

  always #4 clk = ~clk;

  wp_status_unit u0 (
    .clk(clk), .rst(rst), .wel_set_i(wel_set), .wel_clr_i(wel_clr),
    .hw_lock_n_i(pin_n), .busy_i(busy), .sr_wr_i(sr_wr), .sr_data_i(sr_data),
    .op_req_i(op_req), .op_chip_i(op_chip), .op_sector_i(op_sector),
    .status_o(status), .op_grant_o(grant), .op_deny_o(deny)
  );

  function automatic bit sect_protected(int sec, bit all, int lvl);
    int n;
    if (all) return 1;
    n = (lvl == 1) ? 1 : (lvl == 2) ? 2 : (lvl == 3) ? 4 : 0;
    return sec >= 8 - n;
  endfunction

  function automatic bit any_protected(bit all, int lvl);
    return all || lvl != 0;
  endfunction

  always @(posedge clk) begin
    bit ok, evaluated, accepted;
    if (rst) begin
      m_wel <= 0; m_lock <= 0; m_all <= 0; m_lvl <= 0;
      m_busy <= 0; m_grant <= 0; m_deny <= 0;
    end else begin
      ok = op_chip ? !any_protected(m_all, m_lvl)
                   : !sect_protected(int'(op_sector), m_all, m_lvl);
      ok = ok && m_wel && !busy;
      m_grant <= op_req && ok;
      m_deny  <= op_req && !ok;
      evaluated = (sr_wr || op_req) && !busy;
      accepted  = sr_wr && !busy && m_wel && !(m_lock && !pin_n);
      if (accepted) begin
        m_lock <= sr_data[7];
        m_all  <= sr_data[4];
        m_lvl  <= int'(sr_data[3:2]);
      end
      if (wel_clr || evaluated) m_wel <= 0;
      else if (wel_set && !busy) m_wel <= 1;
      m_busy <= busy;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_model();
    chk("R12 busy bit", status[0], m_busy);
    chk("R2/R7 latch bit", status[1], m_wel);
    chk("R3/R8 level bits", status[3:2], m_lvl);
    chk("R3/R8 all bit", status[4], m_all);
    chk("R3 zero bits", status[6:5], 0);
    chk("R5/R6 lock enable", status[7], m_lock);
    chk("R9/R10 grant", grant, m_grant);
    chk("R9/R10 deny", deny, m_deny);
  endtask

  task automatic idle_inputs();
    wel_set = 0; wel_clr = 0; sr_wr = 0; op_req = 0; op_chip = 0;
    sr_data = 8'h00; op_sector = 3'd0; busy = 0;
  endtask

  // Drive for one cycle, then compare after the edge
  task automatic step(bit s, bit c, bit w, logic [7:0] d, bit q, bit ch,
                      logic [2:0] sec, bit b, bit p);
    wel_set = s; wel_clr = c; sr_wr = w; sr_data = d; op_req = q;
    op_chip = ch; op_sector = sec; busy = b; pin_n = p;
    @(negedge clk);
    compare_model();
  endtask

  task automatic set_latch(bit p);
    step(1, 0, 0, 8'h00, 0, 0, 3'd0, 0, p);
  endtask

  task automatic sr_write(logic [7:0] d, bit p);
    step(0, 0, 1, d, 0, 0, 3'd0, 0, p);
  endtask

  task automatic op(bit ch, logic [2:0] sec);
    step(0, 0, 0, 8'h00, 1, ch, sec, 0, 1);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    pin_n = 1;
    rst = 1;
    @(negedge clk); @(negedge clk);
    rst = 0;
    chk("R1 reset status", status, 8'h00);
    chk("R1 reset answers", {grant, deny}, 0);

    set_latch(1);
    chk("R2 latch set", status, 8'h02);
    step(1, 1, 0, 8'h00, 0, 0, 3'd0, 0, 1);
    chk("R2 clear wins over set", status, 8'h00);

    // Level 11 with junk in ignored bits
    set_latch(1);
    sr_write(8'h6F, 1);
    chk("R3 accepted write", status, 8'h0C);
    sr_write(8'h00, 1);
    chk("R4 write without latch", status, 8'h0C);

    // Level 11 covers sectors 4..7
    set_latch(1); op(0, 3'd3);
    chk("R8 sector3 granted level11", {grant, deny}, 2'b10);
    chk("R7 latch used by grant", status[1], 0);
    set_latch(1); op(0, 3'd4);
    chk("R8 sector4 denied level11", {grant, deny}, 2'b01);
    op(0, 3'd0);
    chk("R9 no latch denied", {grant, deny}, 2'b01);
    set_latch(1); op(1, 3'd0);
    chk("R10 chip erase denied", {grant, deny}, 2'b01);

    // Level 01: only sector 7
    set_latch(1); sr_write(8'h04, 1);
    set_latch(1); op(0, 3'd6);
    chk("R8 sector6 granted level01", {grant, deny}, 2'b10);
    set_latch(1); op(0, 3'd7);
    chk("R8 sector7 denied level01", {grant, deny}, 2'b01);
    // Level 10: sectors 6..7
    set_latch(1); sr_write(8'h08, 1);
    set_latch(1); op(0, 3'd5);
    chk("R8 sector5 granted level10", {grant, deny}, 2'b10);
    set_latch(1); op(0, 3'd6);
    chk("R8 sector6 denied level10", {grant, deny}, 2'b01);

    // Unprotected: chip erase allowed
    set_latch(1); sr_write(8'h00, 1);
    set_latch(1); op(1, 3'd0);
    chk("R10 chip erase granted", {grant, deny}, 2'b10);

    // Lock enable with pin low
    set_latch(1); sr_write(8'h80, 1);
    chk("R3 lock enable written", status, 8'h80);
    set_latch(0); sr_write(8'h10, 0);
    chk("R6 pin lock refuses", status, 8'h80);
    chk("R7 latch used by refused write", status[1], 0);
    set_latch(1); sr_write(8'h10, 1);
    chk("R6 pin high allows", status, 8'h10);
    set_latch(1); op(0, 3'd0);
    chk("R8 all bit sector0 denied", {grant, deny}, 2'b01);
    set_latch(0); sr_write(8'h00, 0);
    chk("R5 pin ignored when disabled", status, 8'h00);

    // Busy behaviour
    step(1, 0, 0, 8'h00, 0, 0, 3'd0, 1, 1);
    chk("R11 no set while busy", status, 8'h01);
    set_latch(1);
    step(0, 0, 1, 8'h0C, 0, 0, 3'd0, 1, 1);
    chk("R11 write ignored busy", status[4:1], 4'b0001);
    step(0, 0, 0, 8'h00, 1, 0, 3'd0, 1, 1);
    chk("R11 busy op denied", {grant, deny}, 2'b01);
    chk("R11 latch kept busy", status[1], 1);
    chk("R12 busy bit", status[0], 1);

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      step($urandom_range(0, 2) == 0, $urandom_range(0, 15) == 0,
           $urandom_range(0, 5) == 0, 8'($urandom), $urandom_range(0, 3) == 0,
           $urandom_range(0, 5) == 0, 3'($urandom), $urandom_range(0, 5) == 0,
           $urandom_range(0, 2) != 0);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule